// File: doc/BRIEF.md
# Four-Port Shared Word Memory with Per-Port Write Inhibit

This block is a 2048-word by 8-bit storage array reached through four identical, independent ports. Every port carries its own select, direction, output-enable and write-inhibit controls, its own address and its own data input and output. It is meant for places where several agents exchange data through one shared table and no hardware arbitration is wanted. Any higher-level ordering is handled outside the block, by driving a port's inhibit input low to stop that port's writes.

The model is synchronous to a single clock. A write takes effect at the clock edge. A read is registered, so its word appears one cycle after the request. A per-port drive indication replaces physical three-state buffers: when it is low, the port's data output is forced to zero. Separate outputs report which ports are idle, and whether all four are idle at once.

Top module: `quad_port_ram`

## Requirements
- R1: The array holds 2048 words of 8 bits. Each port has an 11-bit address, and any port can read a word that any other port wrote.
- R2: A port with ceN low, wrN low and busyN high writes its wrData into the addressed word at the clock edge.
- R3: A port with ceN low, wrN high and oeN low at edge n presents the stored word on its rdData slice after edge n, with driveEn high.
- R4: A port with ceN high writes nothing and does not drive: driveEn is low and rdData reads zero after the edge, whatever wrN and oeN are.
- R5: A port with ceN low, wrN high and oeN high does not drive: driveEn is low and rdData is zero after the edge.
- R6: A port that writes in a cycle never drives in the following cycle: driveEn is low, even with oeN low.
- R7: A port with busyN low has its write suppressed, so the word keeps its old value. Reads on that port are unaffected.
- R8: A read of an address that another port writes in the same cycle returns the old word. The new word is visible from the next cycle.
- R9: standby[p] equals ceN[p] combinationally. allStandby is high exactly when all four ceN bits are high.
- R10: While rstN is low, driveEn and rdData are all zero. Array contents are not initialised.
- R11: All four ports may write different addresses in the same cycle, and every such write takes effect.

Top module port slices: port p uses bit p of each 4-bit control bus, addr[p*11 +: 11], and wrData/rdData[p*8 +: 8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the read registers |
| ceN | input | 4 | Per-port select, active low |
| wrN | input | 4 | Per-port direction, low = write, high = read |
| oeN | input | 4 | Per-port output enable, active low |
| busyN | input | 4 | Per-port write inhibit, active low |
| addr | input | 44 | Four 11-bit word addresses |
| wrData | input | 32 | Four 8-bit write words |
| rdData | output | 32 | Four 8-bit read words, zero when not driving |
| driveEn | output | 4 | Per-port drive indication |
| standby | output | 4 | Per-port idle status |
| allStandby | output | 1 | High when all ports are idle |

## Verification
A write stored at the wrong word, or a write that leaks through a raised inhibit, appears only when that word is next read. The full-array sweeps therefore read back every address after each write pass, so a corrupted word shows on rdData one cycle after its read request. A wrong drive decode shows on driveEn and rdData in the cycle right after the request. Errors in the idle outputs show without any clock edge.

// File: rtl/qpram_pkg.sv
package qpram_pkg;
  // Per-port strobes handed from control to datapath.
  typedef struct packed {
    logic wrStb;
    logic rdStb;
  } portStb_t;
endpackage

// File: rtl/qpram_ctrl.sv
module qpram_ctrl
  import qpram_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic [NUM_PORTS-1:0]           ceN,
  input  logic [NUM_PORTS-1:0]           wrN,
  input  logic [NUM_PORTS-1:0]           oeN,
  input  logic [NUM_PORTS-1:0]           busyN,
  output portStb_t [NUM_PORTS-1:0]       stb,
  output logic [NUM_PORTS-1:0]           standby,
  output logic                           allStandby
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
    logic sel;
    assign sel          = ~ceN[p];
    // Inhibit gates only the write path; the read decode ignores it.
    assign stb[p].wrStb = sel & ~wrN[p] & busyN[p];
    assign stb[p].rdStb = sel &  wrN[p] & ~oeN[p];
    assign standby[p]   = ceN[p];
  end

  assign allStandby = &ceN;
endmodule

// File: rtl/qpram_datapath.sv
module qpram_datapath
  import qpram_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  portStb_t [NUM_PORTS-1:0]      stb,
  input  logic [NUM_PORTS*ADDR_W-1:0]   addr,
  input  logic [NUM_PORTS*DATA_W-1:0]   wrData,
  output logic [NUM_PORTS*DATA_W-1:0]   rdData,
  output logic [NUM_PORTS-1:0]          driveEn
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Writes from every port land at the same edge; colliding addresses
  // resolve to the highest-numbered port, which callers must not rely on.
  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (stb[p].wrStb)
        mem[addr[p*ADDR_W +: ADDR_W]] <= wrData[p*DATA_W +: DATA_W];
    end
  end

  // Registered reads see the array value from before this edge's writes.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdData[p*DATA_W +: DATA_W] <= '0;
        driveEn[p]                 <= 1'b0;
      end else if (stb[p].rdStb) begin
        rdData[p*DATA_W +: DATA_W] <= mem[addr[p*ADDR_W +: ADDR_W]];
        driveEn[p]                 <= 1'b1;
      end else begin
        rdData[p*DATA_W +: DATA_W] <= '0;
        driveEn[p]                 <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/quad_port_ram.sv
module quad_port_ram
  import qpram_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_PORTS-1:0]         ceN,
  input  logic [NUM_PORTS-1:0]         wrN,
  input  logic [NUM_PORTS-1:0]         oeN,
  input  logic [NUM_PORTS-1:0]         busyN,
  input  logic [NUM_PORTS*ADDR_W-1:0]  addr,
  input  logic [NUM_PORTS*DATA_W-1:0]  wrData,
  output logic [NUM_PORTS*DATA_W-1:0]  rdData,
  output logic [NUM_PORTS-1:0]         driveEn,
  output logic [NUM_PORTS-1:0]         standby,
  output logic                         allStandby
);
  portStb_t [NUM_PORTS-1:0] stb;

  qpram_ctrl #(.NUM_PORTS(NUM_PORTS)) u_ctrl (
    .ceN        (ceN),
    .wrN        (wrN),
    .oeN        (oeN),
    .busyN      (busyN),
    .stb        (stb),
    .standby    (standby),
    .allStandby (allStandby)
  );

  qpram_datapath #(
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .addr    (addr),
    .wrData  (wrData),
    .rdData  (rdData),
    .driveEn (driveEn)
  );
endmodule

// File: rtl/qpram_checker.sv
module qpram_checker #(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NUM_PORTS-1:0]        ceN,
  input logic [NUM_PORTS-1:0]        wrN,
  input logic [NUM_PORTS-1:0]        oeN,
  input logic [NUM_PORTS*DATA_W-1:0] rdData,
  input logic [NUM_PORTS-1:0]        driveEn,
  input logic [NUM_PORTS-1:0]        standby,
  input logic                        allStandby
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    a_r4_idle_when_deselected: assert property (@(posedge clk) disable iff (!rstN)
      $past(ceN[p]) |-> !driveEn[p]);
    a_r5_drive_needs_read: assert property (@(posedge clk) disable iff (!rstN)
      driveEn[p] |-> $past(!ceN[p] && wrN[p] && !oeN[p]));
    a_r6_no_drive_after_write: assert property (@(posedge clk) disable iff (!rstN)
      $past(!ceN[p] && !wrN[p]) |-> !driveEn[p]);
    a_r4_quiet_output: assert property (@(posedge clk) disable iff (!rstN)
      !driveEn[p] |-> (rdData[p*DATA_W +: DATA_W] == '0));
    a_r9_standby_tracks_ce: assert property (@(posedge clk) disable iff (!rstN)
      standby[p] == ceN[p]);
  end

  a_r9_all_idle: assert property (@(posedge clk) disable iff (!rstN)
    allStandby |-> (&standby));
  a_r9_all_idle_back: assert property (@(posedge clk) disable iff (!rstN)
    (&ceN) |-> allStandby);
endmodule

bind quad_port_ram qpram_checker #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ceN        (ceN),
  .wrN        (wrN),
  .oeN        (oeN),
  .rdData     (rdData),
  .driveEn    (driveEn),
  .standby    (standby),
  .allStandby (allStandby)
);

// File: tb/test_quad_port_ram.sv
module test_quad_port_ram;
  localparam int NP = 4;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN;
  logic [NP-1:0]    ceN, wrN, oeN, busyN;
  logic [NP*AW-1:0] addr;
  logic [NP*DW-1:0] wrData;
  logic [NP*DW-1:0] rdData;
  logic [NP-1:0]    driveEn, standby;
  logic             allStandby;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  logic [DW-1:0] model [DEPTH];

  always #4 clk = ~clk;

  quad_port_ram i_quad_port_ram (
    .clk(clk), .rstN(rstN), .ceN(ceN), .wrN(wrN), .oeN(oeN), .busyN(busyN),
    .addr(addr), .wrData(wrData), .rdData(rdData), .driveEn(driveEn),
    .standby(standby), .allStandby(allStandby)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idleAll();
    ceN = '1; wrN = '1; oeN = '1; busyN = '1; addr = '0; wrData = '0;
  endtask

  task automatic setPort(input int p, input logic ce, input logic wr, input logic oe,
                         input logic bz, input int a, input int d);
    ceN[p] = ce; wrN[p] = wr; oeN[p] = oe; busyN[p] = bz;
    addr[p*AW +: AW] = AW'(a);
    wrData[p*DW +: DW] = DW'(d);
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  function automatic int pat(input int a, input int salt);
    return (a * 37 + salt) & 8'hFF;
  endfunction

  task automatic readSweep(input string req);
    for (int c = 0; c < DEPTH / NP; c++) begin
      idleAll();
      for (int p = 0; p < NP; p++) setPort(p, 0, 1, 0, 1, c*NP + (p+1)%NP, 0);
      tick();
      for (int p = 0; p < NP; p++) begin
        check(req, 32'(rdData[p*DW +: DW]), 32'(model[c*NP + (p+1)%NP]));
        check(req, 32'(driveEn[p]), 32'd1);
      end
    end
  endtask

  initial begin
    idleAll();
    rstN = 1'b0;
    repeat (3) tick();
    // R10: outputs cleared while reset is held
    check("R10", 32'(driveEn), 32'd0);
    check("R10", rdData, 32'd0);
    rstN = 1'b1;
    tick();

    // R11, R2: four simultaneous writes per cycle covering the whole array
    for (int c = 0; c < DEPTH / NP; c++) begin
      idleAll();
      for (int p = 0; p < NP; p++) begin
        setPort(p, 0, 0, 1, 1, c*NP + p, pat(c*NP + p, 5));
        model[c*NP + p] = DW'(pat(c*NP + p, 5));
      end
      tick();
    end
    // R1, R3: cross-port read-back of every word
    readSweep("R1_R3");

    // R7: odd ports inhibited, even ports write
    for (int c = 0; c < DEPTH / NP; c++) begin
      idleAll();
      for (int p = 0; p < NP; p++) begin
        setPort(p, 0, 0, 1, (p % 2 == 0), c*NP + p, pat(c*NP + p, 91) ^ 8'hFF);
        if (p % 2 == 0) model[c*NP + p] = DW'(pat(c*NP + p, 91) ^ 8'hFF);
      end
      tick();
    end
    readSweep("R7");

    // R7: read on an inhibited port is unaffected
    idleAll();
    setPort(1, 0, 1, 0, 0, 6, 0);
    tick();
    check("R7", 32'(rdData[1*DW +: DW]), 32'(model[6]));
    check("R7", 32'(driveEn[1]), 32'd1);

    // R8: same-cycle write and read of one address
    idleAll();
    setPort(0, 0, 0, 1, 1, 5, 8'hA5);
    setPort(1, 0, 1, 0, 1, 5, 0);
    tick();
    check("R8", 32'(rdData[1*DW +: DW]), 32'(model[5]));
    model[5] = 8'hA5;
    idleAll();
    setPort(1, 0, 1, 0, 1, 5, 0);
    tick();
    check("R8", 32'(rdData[1*DW +: DW]), 32'hA5);

    // R4: deselected port with write and read controls asserted
    idleAll();
    setPort(2, 1, 0, 0, 1, 9, 8'h3C);
    #1;
    check("R4", 32'(standby[2]), 32'd1);
    tick();
    check("R4", 32'(driveEn[2]), 32'd0);
    check("R4", 32'(rdData[2*DW +: DW]), 32'd0);
    idleAll();
    setPort(3, 0, 1, 0, 1, 9, 0);
    tick();
    check("R4", 32'(rdData[3*DW +: DW]), 32'(model[9]));

    // R5: read with output enable inactive
    idleAll();
    setPort(0, 0, 1, 1, 1, 9, 0);
    tick();
    check("R5", 32'(driveEn[0]), 32'd0);
    check("R5", 32'(rdData[0*DW +: DW]), 32'd0);

    // R6: write with output enable active gives no drive
    idleAll();
    setPort(3, 0, 0, 0, 1, 12, 8'h5A);
    model[12] = 8'h5A;
    tick();
    check("R6", 32'(driveEn[3]), 32'd0);
    check("R6", 32'(rdData[3*DW +: DW]), 32'd0);

    // R9: every chip-select combination
    for (int m = 0; m < 16; m++) begin
      idleAll();
      ceN = 4'(m);
      #1;
      check("R9", 32'(standby), 32'(m));
      check("R9", 32'(allStandby), 32'(m == 15));
      tick();
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule